// File: doc/BRIEF.md
# Character-Cell Raster Video Generator

This block produces the raster timing and display stream for a 256x192 bitmap organised as 32 columns by 24 rows of 8x8 character cells. It runs from a single master clock. Every second master cycle is one dot. A four-bit Johnson counter splits each character into eight dots, and two counters track the character within the line and the line within the frame.

For each visible character the block fetches two bytes from video RAM: a pixel byte and an attribute byte. Both addresses share the same low seven bits. It serialises the pixel byte most significant bit first and picks the ink or paper colour from the attribute. Flash and bright are applied, and the border colour is used outside the bitmap. Sync and blanking are generated from the counters.

The system drives a configuration bit that moves the screen between the lower and upper halves of the address space. The video RAM returns the addressed byte combinationally during the strobe cycle.

Top module: `char_video_gen`

## Requirements
- R1: While rst_ni is low, rgb_o, bright_o, hsync_o, vsync_o, blank_o, pix_stb_o and attr_stb_o are all 0.
- R2: The dot position advances on every second master cycle. A character lasts 8 dots. In each visible character, pix_stb_o is high in the second master cycle of dot 2, and attr_stb_o is high in the second master cycle of dot 6, exactly 8 master cycles later. The Johnson phase changes one bit per step.
- R3: A line is CHARS_PER_LINE characters long, so hsync_o rises every CHARS_PER_LINE*16 master cycles. hsync_o is high at a dot exactly when the character index of the preceding dot is in [HSYNC_START, HSYNC_START+HSYNC_LEN).
- R4: A frame is LINES_PER_FRAME lines long. vsync_o is high at a dot exactly when the line index of the preceding dot is in [VSYNC_START, VSYNC_START+VSYNC_LEN), so it rises every LINES_PER_FRAME*CHARS_PER_LINE*16 master cycles.
- R5: With column c (0..31) and line v, the pixel address is {x, 1, 0, v[7:6], v[2:0], v[5:3], c[4:0]}, where x is cfg_alt_i. It is driven during the pix_stb_o cycle.
- R6: The attribute address is {x, 1, 0, 1, 1, 0, v[7:6], v[5:3], c[4:0]}. It is driven during the attr_stb_o cycle, and its low 7 bits equal those of the pixel address 8 cycles earlier.
- R7: Strobes occur only for characters with index below 32 on lines below ACTIVE_LINES. Every such character gets exactly one pixel strobe followed by one attribute strobe, in column order, line by line.
- R8: Bit k of the pixel byte fetched for column c is shown at line dot (c+1)*8+10-k. A 1 selects ink (attribute bits 2:0) and a 0 selects paper (attribute bits 5:3). rgb_o carries the chosen 3-bit index unchanged.
- R9: At dots that show no bitmap pixel and are not blanked, rgb_o equals the border_i value sampled at that dot's step and bright_o is 0.
- R10: blank_o is high at a dot exactly when the preceding dot's character index is in [HBLANK_START, HBLANK_END). While blank_o is high, rgb_o and bright_o are 0.
- R11: bright_o equals attribute bit 6 for bitmap pixels whose selected colour is non-zero. It is 0 for black and for the border.
- R12: When attribute bit 7 is set and the flash phase is 1, ink and paper swap. The flash phase is 0 after reset and inverts at every FLASH_FRAMES-th frame wrap, so it never changes during visible lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (twice the dot rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_alt_i | input | 1 | Screen half select, address bit 15 |
| border_i | input | 3 | Border colour index |
| vram_data_i | input | 8 | Byte returned by video RAM for vram_addr_o |
| vram_addr_o | output | 16 | Video RAM address |
| pix_stb_o | output | 1 | Pixel byte capture strobe |
| attr_stb_o | output | 1 | Attribute byte capture strobe |
| rgb_o | output | 3 | Colour index |
| bright_o | output | 1 | Intensity |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Horizontal blanking |

## Verification
The bench builds the block with 36 characters per line, 80 lines per frame, 72 active lines and a flash period of one frame. The blanking and horizontal sync both start at character 34, and vertical sync covers lines 76 and 77.

These values fit two full frames and part of a third into the cycle budget. The active lines reach past line 63, so the second screen-third field value shows up in the addresses. Both flash phases appear, and the half-select and border inputs can be changed between frames. Every dot is compared against a bench model of colour, bright, sync and blanking. A queue holds the expected address of every strobe.

// File: rtl/cvg_pkg.sv
package cvg_pkg;
  localparam int VIS_COLS = 32;

  // Johnson state -> dot index within a character
  function automatic logic [2:0] jc_phase(input logic [3:0] j);
    case (j)
      4'b0000: return 3'd0;
      4'b0001: return 3'd1;
      4'b0011: return 3'd2;
      4'b0111: return 3'd3;
      4'b1111: return 3'd4;
      4'b1110: return 3'd5;
      4'b1100: return 3'd6;
      4'b1000: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] pick_colour(input logic pix, input logic [7:0] attr,
                                             input logic flash_ph);
    logic sel_ink;
    sel_ink = pix ^ (attr[7] & flash_ph);
    return sel_ink ? attr[2:0] : attr[5:3];
  endfunction
endpackage

// File: rtl/cvg_timing.sv
module cvg_timing #(
  parameter int CHARS    = 56,
  parameter int LINES    = 312,
  parameter int HS_START = 42,
  parameter int HS_LEN   = 4,
  parameter int HB_START = 40,
  parameter int HB_END   = 56,
  parameter int VS_START = 248,
  parameter int VS_LEN   = 4,
  parameter int HW       = 6,
  parameter int VW       = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          dot_en_o,
  output logic [2:0]    phase_o,
  output logic          slot_end_o,
  output logic          frame_end_o,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          hsync_raw_o,
  output logic          hblank_raw_o,
  output logic          vsync_raw_o
);
  import cvg_pkg::*;

  localparam logic [HW-1:0] H_LAST = HW'(CHARS - 1);
  localparam logic [VW-1:0] V_LAST = VW'(LINES - 1);
  localparam logic [HW-1:0] HS_A   = HW'(HS_START);
  localparam logic [HW-1:0] HS_B   = HW'(HS_START + HS_LEN);
  localparam logic [HW-1:0] HB_A   = HW'(HB_START);
  localparam logic [HW-1:0] HB_B   = HW'(HB_END);
  localparam logic [VW-1:0] VS_A   = VW'(VS_START);
  localparam logic [VW-1:0] VS_B   = VW'(VS_START + VS_LEN);

  logic          div_q;
  logic [3:0]    jc_q;
  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          line_end;

  assign dot_en_o    = div_q;
  assign phase_o     = jc_phase(jc_q);
  assign slot_end_o  = div_q && (jc_q == 4'b1000);
  assign line_end    = slot_end_o && (hcnt_q == H_LAST);
  assign frame_end_o = line_end && (vcnt_q == V_LAST);
  assign hcnt_o      = hcnt_q;
  assign vcnt_o      = vcnt_q;

  assign hsync_raw_o  = (hcnt_q >= HS_A) && (hcnt_q < HS_B);
  assign hblank_raw_o = (hcnt_q >= HB_A) && (hcnt_q < HB_B);
  assign vsync_raw_o  = (vcnt_q >= VS_A) && (vcnt_q < VS_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= 1'b0;
      jc_q   <= 4'b0000;
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      div_q <= ~div_q;
      if (div_q) jc_q <= {jc_q[2:0], ~jc_q[3]};
      if (slot_end_o) hcnt_q <= (hcnt_q == H_LAST) ? '0 : hcnt_q + 1'b1;
      if (line_end)   vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
    end
  end

  AST_JC_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(jc_q ^ $past(jc_q)) <= 1); // R2
  AST_DOT_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_en_o |=> !dot_en_o); // R2
  AST_HCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= H_LAST); // R3
  AST_VCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcnt_q <= V_LAST); // R4
endmodule

// File: rtl/cvg_fetch.sv
module cvg_fetch #(
  parameter int ACTIVE_LINES = 192,
  parameter int HW           = 6,
  parameter int VW           = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dot_en_i,
  input  logic [2:0]    phase_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic          cfg_alt_i,
  output logic [15:0]   addr_o,
  output logic          pix_stb_o,
  output logic          attr_stb_o,
  output logic          active_o
);
  import cvg_pkg::*;

  localparam logic [HW-1:0] COL_LIM  = HW'(VIS_COLS);
  localparam logic [VW-1:0] LINE_LIM = VW'(ACTIVE_LINES);

  logic [4:0]  col;
  logic [1:0]  third;
  logic [2:0]  cell_row, scan;
  logic [15:0] pix_addr, attr_addr;

  assign col      = hcnt_i[4:0];
  assign scan     = vcnt_i[2:0];
  assign cell_row = vcnt_i[5:3];
  assign third    = vcnt_i[7:6];

  assign pix_addr  = {cfg_alt_i, 2'b10, third, scan, cell_row, col};
  assign attr_addr = {cfg_alt_i, 2'b10, 3'b110, third, cell_row, col};

  assign active_o   = (hcnt_i < COL_LIM) && (vcnt_i < LINE_LIM);
  assign addr_o     = phase_i[2] ? attr_addr : pix_addr;
  assign pix_stb_o  = active_o && dot_en_i && (phase_i == 3'd2);
  assign attr_stb_o = active_o && dot_en_i && (phase_i == 3'd6);

  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_stb_o && attr_stb_o)); // R7
  AST_ATTR_FOLLOWS_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_stb_o |-> $past(pix_stb_o, 8)); // R2
  AST_SHARED_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_stb_o |-> (addr_o[6:0] == $past(addr_o[6:0], 8))); // R6
endmodule

// File: rtl/cvg_pixel.sv
module cvg_pixel #(
  parameter int FLASH_FRAMES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dot_en_i,
  input  logic [2:0] phase_i,
  input  logic       slot_end_i,
  input  logic       frame_end_i,
  input  logic       active_i,
  input  logic       pix_stb_i,
  input  logic       attr_stb_i,
  input  logic [7:0] vram_data_i,
  input  logic [2:0] border_i,
  input  logic       hsync_raw_i,
  input  logic       hblank_raw_i,
  input  logic       vsync_raw_i,
  output logic [2:0] rgb_o,
  output logic       bright_o,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       blank_o
);
  import cvg_pkg::*;

  localparam int FW = $clog2(FLASH_FRAMES + 1);
  localparam logic [FW-1:0] F_LAST = FW'(FLASH_FRAMES - 1);

  logic [7:0]    pix_hold, attr_hold, shift_q, attr_q;
  logic          vis_pend, vis_q, d1_q, d2_q;
  logic          flash_q;
  logic [FW-1:0] fcnt_q;
  logic [2:0]    col_next, ink_paper;
  logic          br_next;

  assign ink_paper = pick_colour(d2_q, attr_q, flash_q);

  always_comb begin
    col_next = border_i;
    br_next  = 1'b0;
    if (hblank_raw_i) begin
      col_next = 3'd0;
    end else if (vis_q) begin
      col_next = ink_paper;
      br_next  = attr_q[6] && (ink_paper != 3'd0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_hold  <= '0;
      attr_hold <= '0;
      shift_q   <= '0;
      attr_q    <= '0;
      vis_pend  <= 1'b0;
      vis_q     <= 1'b0;
      d1_q      <= 1'b0;
      d2_q      <= 1'b0;
      flash_q   <= 1'b0;
      fcnt_q    <= '0;
      rgb_o     <= '0;
      bright_o  <= 1'b0;
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      blank_o   <= 1'b0;
    end else begin
      if (pix_stb_i)  pix_hold  <= vram_data_i;
      if (attr_stb_i) attr_hold <= vram_data_i;
      if (dot_en_i) begin
        if (slot_end_i) begin
          shift_q  <= pix_hold;
          vis_pend <= active_i;
        end else begin
          shift_q  <= {shift_q[6:0], 1'b0};
        end
        // two-dot delay lines the pixel up with the later attribute load
        d1_q <= shift_q[7];
        d2_q <= d1_q;
        if (phase_i == 3'd1) begin
          attr_q <= attr_hold;
          vis_q  <= vis_pend;
        end
        rgb_o    <= col_next;
        bright_o <= br_next;
        hsync_o  <= hsync_raw_i;
        vsync_o  <= vsync_raw_i;
        blank_o  <= hblank_raw_i;
      end
      if (frame_end_i) begin
        if (fcnt_q == F_LAST) begin
          fcnt_q  <= '0;
          flash_q <= ~flash_q;
        end else begin
          fcnt_q  <= fcnt_q + 1'b1;
        end
      end
    end
  end

  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (rgb_o == 3'd0) && !bright_o); // R10
  AST_BRIGHT_NONBLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bright_o |-> (rgb_o != 3'd0)); // R11
  AST_FLASH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flash_q) |-> $past(frame_end_i)); // R12
  AST_OUT_ON_DOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dot_en_i) |-> $stable(rgb_o)); // R2
endmodule

// File: rtl/char_video_gen.sv
module char_video_gen #(
  parameter int CHARS_PER_LINE  = 56,
  parameter int LINES_PER_FRAME = 312,
  parameter int ACTIVE_LINES    = 192,
  parameter int HSYNC_START     = 42,
  parameter int HSYNC_LEN       = 4,
  parameter int HBLANK_START    = 40,
  parameter int HBLANK_END      = 56,
  parameter int VSYNC_START     = 248,
  parameter int VSYNC_LEN       = 4,
  parameter int FLASH_FRAMES    = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_alt_i,
  input  logic [2:0]  border_i,
  input  logic [7:0]  vram_data_i,
  output logic [15:0] vram_addr_o,
  output logic        pix_stb_o,
  output logic        attr_stb_o,
  output logic [2:0]  rgb_o,
  output logic        bright_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        blank_o
);
  localparam int HW_RAW = $clog2(CHARS_PER_LINE);
  localparam int VW_RAW = $clog2(LINES_PER_FRAME);
  localparam int HW     = (HW_RAW > 6) ? HW_RAW : 6;
  localparam int VW     = (VW_RAW > 8) ? VW_RAW : 8;

  logic          dot_en, slot_end, frame_end, active;
  logic          hsync_raw, hblank_raw, vsync_raw;
  logic [2:0]    phase;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  cvg_timing #(
    .CHARS(CHARS_PER_LINE), .LINES(LINES_PER_FRAME),
    .HS_START(HSYNC_START), .HS_LEN(HSYNC_LEN),
    .HB_START(HBLANK_START), .HB_END(HBLANK_END),
    .VS_START(VSYNC_START), .VS_LEN(VSYNC_LEN),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dot_en_o(dot_en), .phase_o(phase), .slot_end_o(slot_end),
    .frame_end_o(frame_end), .hcnt_o(hcnt), .vcnt_o(vcnt),
    .hsync_raw_o(hsync_raw), .hblank_raw_o(hblank_raw), .vsync_raw_o(vsync_raw)
  );

  cvg_fetch #(
    .ACTIVE_LINES(ACTIVE_LINES), .HW(HW), .VW(VW)
  ) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .dot_en_i(dot_en), .phase_i(phase),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .cfg_alt_i(cfg_alt_i),
    .addr_o(vram_addr_o), .pix_stb_o(pix_stb_o), .attr_stb_o(attr_stb_o),
    .active_o(active)
  );

  cvg_pixel #(
    .FLASH_FRAMES(FLASH_FRAMES)
  ) u_pixel (
    .clk_i(clk_i), .rst_ni(rst_ni), .dot_en_i(dot_en), .phase_i(phase),
    .slot_end_i(slot_end), .frame_end_i(frame_end), .active_i(active),
    .pix_stb_i(pix_stb_o), .attr_stb_i(attr_stb_o), .vram_data_i(vram_data_i),
    .border_i(border_i), .hsync_raw_i(hsync_raw), .hblank_raw_i(hblank_raw),
    .vsync_raw_i(vsync_raw), .rgb_o(rgb_o), .bright_o(bright_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o)
  );
endmodule

// File: tb/char_video_gen_bench.sv
module char_video_gen_bench;
  localparam int CH = 36, LN = 80, ACT = 72;
  localparam int HSS = 34, HSL = 1, HBS = 34, HBE = 36, VSS = 76, VSL = 2, FL = 1;
  localparam int LD = CH * 8;
  localparam int FD = LD * LN;
  localparam int END_G = 2 * FD + 10 * LD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_alt = 1'b0;
  logic [2:0]  border = 3'b101;
  logic [7:0]  vdata;
  logic [15:0] vaddr;
  logic        pstb, astb, bright, hs, vs, blank;
  logic [2:0]  rgb;

  int errors = 0;
  int checks = 0;
  int e = 0;
  logic [2:0]  bstep = 3'b101;
  logic [16:0] exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h3C;
  endfunction

  assign vdata = mem_f(vaddr);

  char_video_gen #(
    .CHARS_PER_LINE(CH), .LINES_PER_FRAME(LN), .ACTIVE_LINES(ACT),
    .HSYNC_START(HSS), .HSYNC_LEN(HSL), .HBLANK_START(HBS), .HBLANK_END(HBE),
    .VSYNC_START(VSS), .VSYNC_LEN(VSL), .FLASH_FRAMES(FL)
  ) u_char_video_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_alt_i(cfg_alt), .border_i(border),
    .vram_data_i(vdata), .vram_addr_o(vaddr), .pix_stb_o(pstb), .attr_stb_o(astb),
    .rgb_o(rgb), .bright_o(bright), .hsync_o(hs), .vsync_o(vs), .blank_o(blank)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pix_a(input bit x, input int v, input int c);
    logic [7:0] vv;
    logic [4:0] cc;
    vv = 8'(v);
    cc = 5'(c);
    return {x, 2'b10, vv[7:6], vv[2:0], vv[5:3], cc};
  endfunction

  function automatic logic [15:0] attr_a(input bit x, input int v, input int c);
    logic [7:0] vv;
    logic [4:0] cc;
    vv = 8'(v);
    cc = 5'(c);
    return {x, 2'b10, 3'b110, vv[7:6], vv[5:3], cc};
  endfunction

  // driver: expected strobe addresses for one frame
  task automatic push_frame(input bit x);
    for (int v = 0; v < ACT; v++)
      for (int c = 0; c < 32; c++) begin
        exp_q.push_back({1'b0, pix_a(x, v, c)});
        exp_q.push_back({1'b1, attr_a(x, v, c)});
      end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      e = e + 1;
      if (e % 2 == 0) bstep = border;
    end
  end

  int last_p = 0, last_hs = 0, last_vs = 0;
  logic prev_hs = 1'b0, prev_vs = 1'b0;

  // monitor
  always @(negedge clk) begin : mon
    int g, p, v, f, q, qc, qv, c, k, fp;
    bit exp_p, exp_a, exp_bl, exp_hs, exp_vs, xs, sel, exp_br;
    logic [2:0]  exp_rgb;
    logic [7:0]  pb, ab;
    logic [16:0] item;
    string req;
    if (rst_n && e > 0) begin
      g = e / 2;
      p = g % LD;
      v = (g / LD) % LN;
      f = g / FD;
      exp_p = (e % 2 == 1) && (p / 8 < 32) && (v < ACT) && (p % 8 == 2);
      exp_a = (e % 2 == 1) && (p / 8 < 32) && (v < ACT) && (p % 8 == 6);
      chk(pstb == exp_p, "R7", "pixel strobe", int'(pstb), int'(exp_p));
      chk(astb == exp_a, "R2", "attr strobe", int'(astb), int'(exp_a));
      if (pstb) last_p = e;
      if (astb) chk(e - last_p == 8, "R2", "attr after pixel strobe", e - last_p, 8);
      if (pstb || astb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected strobe", int'(vaddr), 0);
        end else begin
          item = exp_q.pop_front();
          chk(item[16] == astb, "R7", "strobe kind", int'(astb), int'(item[16]));
          if (item[16]) chk(vaddr == item[15:0], "R6", "attr address", int'(vaddr), int'(item[15:0]));
          else          chk(vaddr == item[15:0], "R5", "pixel address", int'(vaddr), int'(item[15:0]));
        end
      end
      if (g >= 1) begin
        q  = g - 1;
        qc = (q % LD) / 8;
        qv = (q / LD) % LN;
        exp_bl = (qc >= HBS) && (qc < HBE);
        exp_hs = (qc >= HSS) && (qc < HSS + HSL);
        exp_vs = (qv >= VSS) && (qv < VSS + VSL);
        chk(blank == exp_bl, "R10", "blank", int'(blank), int'(exp_bl));
        chk(hs == exp_hs, "R3", "hsync", int'(hs), int'(exp_hs));
        chk(vs == exp_vs, "R4", "vsync", int'(vs), int'(exp_vs));
        if (exp_bl) begin
          exp_rgb = 3'd0; exp_br = 1'b0; req = "R10";
        end else if (p >= 11 && ((p - 3) / 8 - 1) < 32 && v < ACT) begin
          c  = (p - 3) / 8 - 1;
          k  = 7 - ((p - 3) % 8);
          xs = (f != 0);
          pb = mem_f(pix_a(xs, v, c));
          ab = mem_f(attr_a(xs, v, c));
          fp = (f / FL) % 2;
          sel = pb[k] ^ (ab[7] && fp == 1);
          exp_rgb = sel ? ab[2:0] : ab[5:3];
          exp_br  = ab[6] && (exp_rgb != 3'd0);
          req = (ab[7] && fp == 1) ? "R12" : "R8";
        end else begin
          exp_rgb = bstep; exp_br = 1'b0; req = "R9";
        end
        chk(rgb == exp_rgb, req, "colour", int'(rgb), int'(exp_rgb));
        chk(bright == exp_br, "R11", "bright", int'(bright), int'(exp_br));
      end
      if (hs && !prev_hs) begin
        if (last_hs > 0) chk(e - last_hs == 2 * LD, "R3", "line period", e - last_hs, 2 * LD);
        last_hs = e;
      end
      if (vs && !prev_vs) begin
        if (last_vs > 0) chk(e - last_vs == 2 * FD, "R4", "frame period", e - last_vs, 2 * FD);
        last_vs = e;
      end
      prev_hs = hs;
      prev_vs = vs;
    end
  end

  // screen half and border change between frames 0 and 1
  initial begin
    wait (rst_n && e / 2 >= ACT * LD + 2 * LD);
    @(negedge clk);
    cfg_alt = 1'b1;
    border  = 3'b010;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rgb == 3'd0, "R1", "reset rgb", int'(rgb), 0);
    chk(bright == 1'b0, "R1", "reset bright", int'(bright), 0);
    chk(hs == 1'b0 && vs == 1'b0, "R1", "reset sync", int'({hs, vs}), 0);
    chk(blank == 1'b0, "R1", "reset blank", int'(blank), 0);
    chk(pstb == 1'b0 && astb == 1'b0, "R1", "reset strobes", int'({pstb, astb}), 0);
    push_frame(1'b0);
    push_frame(1'b1);
    push_frame(1'b1);
    rst_n = 1'b1;
    wait (e >= 2 * END_G);
    @(negedge clk);
    chk(exp_q.size() == (ACT - 10) * 64, "R7", "strobe count", exp_q.size(), (ACT - 10) * 64);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", e, 2 * END_G);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule